// File: doc/BRIEF.md
# E1 CAS Signaling Inserter

This block sits on a 2.048 Mbit/s E1 transmit path and writes Channel Associated Signaling into time slot 16 of a bit-serial PCM stream. Each PCM bit enters on one clock and leaves, possibly replaced, on the next. A frame-sync pulse marks the first bit of time slot 0. A multiframe-sync pulse, given together with the frame sync, marks frame 0 of a 16-frame multiframe. When no sync arrives, the internal bit, slot and frame counters keep running on their own.

Signaling reaches the block from two sources. The host writes sixteen 8-bit signaling registers, one for each frame of the multiframe. The block copies all sixteen into a shadow buffer only at a multiframe start, so the host can update them at any time without tearing a multiframe. A serial signaling input runs in step with the PCM input. Two 32-bit masks, indexed by time slot, decide per channel whether the shadow buffer or the serial input supplies that channel's ABCD nibble. The serial input wins when a channel is selected in both masks. A latched flag rises at every multiframe start so the host knows when to refresh the registers.

Top module: `e1_cas_inserter`

## Requirements
- R1: Bits of every slot other than 16 leave `pcmOut` exactly one clock after they enter on `pcmIn`. Bit 7 of a slot is the first bit and the slot with `frameSync` high is slot 0, bit 7.
- R2: With the global enable (address 16, bit 0) at 0, slot 16 also passes through unchanged.
- R3: With the enable at 1, slot 16 of frame 0 carries 0000 in bits 7..4 and bits 3..0 of buffered register 0 in bits 3..0.
- R4: In frame n (1..15), bits 7..4 of slot 16 carry the ABCD nibble of slot n and bits 3..0 carry that of slot n+16, taken from buffered register n when the slot's software-enable bit (address 17, bit = slot number) is 1.
- R5: A nibble whose slot has neither mask bit set keeps the bits that arrived on `pcmIn`.
- R6: A nibble whose slot has its hardware-select bit (address 18, bit = slot number) set carries the bits present on `sigIn` in the same cycles. This holds whatever the slot's software-enable bit is.
- R7: Registers 0..15 (addresses 0..15, data bits 7..0) reach the buffer only in the cycle of a multiframe start. A write made at any other time, or in that same cycle, shows up from the next multiframe on.
- R8: `mfFlag` is 1 from the clock after each multiframe start and stays 1.
- R9: Writing data bit 0 = 1 to address 19 clears `mfFlag` on the next clock. Writing 0 there has no effect. A multiframe start in the same cycle as the clearing write leaves the flag set.
- R10: During and after reset, `pcmOut` is 0, `mfFlag` is 0, and all registers, masks and the enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 5 | Write address: 0..15 signaling, 16 enable, 17 software mask, 18 hardware mask, 19 flag clear |
| wrData | input | 32 | Write data |
| pcmIn | input | 1 | Serial PCM input |
| sigIn | input | 1 | Serial signaling input, aligned with pcmIn |
| frameSync | input | 1 | High on bit 7 of slot 0 |
| mfSync | input | 1 | High with frameSync on frame 0 |
| pcmOut | output | 1 | Serial PCM output, one clock behind pcmIn |
| mfFlag | output | 1 | Latched multiframe-start flag |

## Verification
Two pairs of events can land on the same clock edge. The first is a host write to a signaling register in the multiframe-start cycle, which overlaps the buffer capture. The second is a flag-clearing write in that cycle, which overlaps the flag set. The bench runs the stream up to the bit just before frame 0, then issues each write on the boundary bit itself. It then reads back through `pcmOut` that the slot 16 byte of the affected frame still holds the old value in the current multiframe and the new value in the next one, and reads at `mfFlag` that the flag stayed set.

// File: rtl/e1sig_pkg.sv
package e1sig_pkg;
  localparam int SLOTS    = 32;
  localparam int FRAMES   = 16;
  localparam int SIG_SLOT = 16;
  localparam int BYTE_W   = 8;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int FRAME_W  = $clog2(FRAMES);
  localparam int BIT_W    = $clog2(BYTE_W);
  localparam int POS_W    = SLOT_W + BIT_W;
  localparam int ADDR_W   = 5;
  localparam int DATA_W   = SLOTS;

  localparam logic [ADDR_W-1:0] ADDR_CTL   = ADDR_W'(FRAMES);
  localparam logic [ADDR_W-1:0] ADDR_SWEN  = ADDR_W'(FRAMES + 1);
  localparam logic [ADDR_W-1:0] ADDR_HWSEL = ADDR_W'(FRAMES + 2);
  localparam logic [ADDR_W-1:0] ADDR_STAT  = ADDR_W'(FRAMES + 3);

  // strobes from control to datapath, valid for the bit currently on pcmIn
  typedef struct packed {
    logic               mfStart;
    logic               inSig;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   bitIdx;
    logic               wrSig;
    logic               wrCtl;
    logic               wrSwEn;
    logic               wrHwSel;
  } strobe_t;
endpackage

// File: rtl/e1sig_ctrl.sv
module e1sig_ctrl
  import e1sig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSync,
  input  logic              mfSync,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              clrBit,
  output strobe_t           st,
  output logic              mfFlag
);
  logic [POS_W-1:0]   posReg, curPos;
  logic [FRAME_W-1:0] frameReg, curFrame;
  logic               clrHit;

  always_comb begin
    curPos = frameSync ? '0 : posReg + 1'b1;
    if (frameSync)          curFrame = mfSync ? '0 : frameReg + 1'b1;
    else if (curPos == '0)  curFrame = frameReg + 1'b1;
    else                    curFrame = frameReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posReg   <= '0;
      frameReg <= '0;
    end else begin
      posReg   <= curPos;
      frameReg <= curFrame;
    end
  end

  always_comb begin
    st.mfStart = (curPos == '0) && (curFrame == '0);
    st.inSig   = curPos[POS_W-1:BIT_W] == SLOT_W'(SIG_SLOT);
    st.frame   = curFrame;
    st.bitIdx  = BIT_W'(BYTE_W - 1) - curPos[BIT_W-1:0];
    st.wrSig   = wrEn && (wrAddr < ADDR_W'(FRAMES));
    st.wrCtl   = wrEn && (wrAddr == ADDR_CTL);
    st.wrSwEn  = wrEn && (wrAddr == ADDR_SWEN);
    st.wrHwSel = wrEn && (wrAddr == ADDR_HWSEL);
  end

  assign clrHit = wrEn && (wrAddr == ADDR_STAT) && clrBit;

  // set has priority over a clearing write in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           mfFlag <= 1'b0;
    else if (st.mfStart) mfFlag <= 1'b1;
    else if (clrHit)     mfFlag <= 1'b0;
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    st.mfStart |=> mfFlag);
  assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (mfFlag && !clrHit) |=> mfFlag);
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && !st.mfStart) |=> !mfFlag);
endmodule

// File: rtl/e1sig_dpath.sv
module e1sig_dpath
  import e1sig_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [FRAME_W-1:0] regIdx,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               pcmIn,
  input  logic               sigIn,
  output logic               pcmOut
);
  logic [FRAMES-1:0][BYTE_W-1:0] sigReg, sigBuf;
  logic                          enReg;
  logic [SLOTS-1:0]              swEn, hwSel;
  logic [1:0]                    laneHw, laneSw;
  logic [BYTE_W-1:0]             curByte;
  logic                          upperHalf, nextBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sigReg <= '0;
      enReg  <= 1'b0;
      swEn   <= '0;
      hwSel  <= '0;
    end else begin
      if (st.wrSig)   sigReg[regIdx] <= wrData[BYTE_W-1:0];
      if (st.wrCtl)   enReg <= wrData[0];
      if (st.wrSwEn)  swEn  <= wrData;
      if (st.wrHwSel) hwSel <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           sigBuf <= '0;
    else if (st.mfStart) sigBuf <= sigReg;
  end

  // lane 1 = upper nibble (slot n), lane 0 = lower nibble (slot n+16)
  for (genvar h = 0; h < 2; h++) begin : g_lane
    localparam logic [SLOT_W-1:0] OFFS = (h == 1) ? '0 : SLOT_W'(SIG_SLOT);
    logic [SLOT_W-1:0] laneTs;
    assign laneTs    = SLOT_W'(st.frame) + OFFS;
    assign laneHw[h] = hwSel[laneTs];
    assign laneSw[h] = swEn[laneTs];
  end

  always_comb begin
    upperHalf = st.bitIdx >= BIT_W'(BYTE_W / 2);
    curByte   = sigBuf[st.frame];
    nextBit   = pcmIn;
    if (enReg && st.inSig) begin
      if (st.frame == '0)
        nextBit = upperHalf ? 1'b0 : curByte[st.bitIdx];
      else if (laneHw[upperHalf])
        nextBit = sigIn;
      else if (laneSw[upperHalf])
        nextBit = curByte[st.bitIdx];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pcmOut <= 1'b0;
    else       pcmOut <= nextBit;
  end

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    !st.inSig |=> pcmOut == $past(pcmIn));
  assert_gate_R2: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |=> pcmOut == $past(pcmIn));
  assert_mfas_R3: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && st.inSig && st.frame == '0 && st.bitIdx[BIT_W-1]) |=> !pcmOut);
  assert_hw_prio_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && st.inSig && st.frame != '0 &&
     (st.bitIdx[BIT_W-1] ? hwSel[st.frame] : hwSel[SLOT_W'(st.frame) + SLOT_W'(SIG_SLOT)]))
    |=> pcmOut == $past(sigIn));
  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    st.mfStart |=> sigBuf == $past(sigReg));
  assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !st.mfStart |=> $stable(sigBuf));
endmodule

// File: rtl/e1_cas_inserter.sv
module e1_cas_inserter
  import e1sig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcmIn,
  input  logic              sigIn,
  input  logic              frameSync,
  input  logic              mfSync,
  output logic              pcmOut,
  output logic              mfFlag
);
  strobe_t st;

  e1sig_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frameSync(frameSync),
    .mfSync   (mfSync),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .clrBit   (wrData[0]),
    .st       (st),
    .mfFlag   (mfFlag)
  );

  e1sig_dpath u_dpath (
    .clk   (clk),
    .rstN  (rstN),
    .st    (st),
    .regIdx(wrAddr[FRAME_W-1:0]),
    .wrData(wrData),
    .pcmIn (pcmIn),
    .sigIn (sigIn),
    .pcmOut(pcmOut)
  );
endmodule

// File: tb/e1_cas_inserter_tb.sv
`timescale 1ns/1ps
module e1_cas_inserter_tb;
  import e1sig_pkg::*;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic pcmIn = 1'b0, sigIn = 1'b0, frameSync = 1'b0, mfSync = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic pcmOut, mfFlag;

  always #2.5 clk = ~clk;

  e1_cas_inserter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pcmIn(pcmIn), .sigIn(sigIn), .frameSync(frameSync), .mfSync(mfSync),
    .pcmOut(pcmOut), .mfFlag(mfFlag)
  );

  int nRun = 0, nFail = 0;
  bit done = 1'b0;
  int gF = 0, gS = 0, gB = 0, frameErr = 0, flagErr = 0;
  logic [7:0]  shadowM [16];
  logic [7:0]  snapM   [16];
  logic        enM = 1'b0, flagM = 1'b0;
  logic [31:0] swM = '0, hwM = '0;
  logic [15:0] lfsr = 16'hACE1;
  string curTag = "R1";

  typedef struct packed {
    logic        en;
    logic [31:0] sw;
    logic [31:0] hw;
    logic [7:0]  seed;
  } row_t;
  localparam int NROWS = 6;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 8'h11},
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'h27},
    '{1'b1, 32'hAAAA_5555, 32'h0000_0000, 8'h3C},
    '{1'b1, 32'h0000_0000, 32'hFFFF_FFFF, 8'h42},
    '{1'b1, 32'hFFFF_0000, 32'h0F0F_0F0F, 8'h5D},
    '{1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'h6E}
  };
  localparam string ROW_TAG [NROWS] = '{"R2", "R4", "R5", "R6", "R6", "R1"};

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // one bit of stream; model follows the requirements
  task automatic step(input logic doWr, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    logic p, s, bnd, expBit;
    int bi, ts;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    p = lfsr[0];
    s = lfsr[5];
    bnd = (gF == 0 && gS == 0 && gB == 0);
    pcmIn = p; sigIn = s;
    frameSync = (gS == 0 && gB == 0); mfSync = bnd;
    wrEn = doWr; wrAddr = a; wrData = d;
    if (bnd) begin
      for (int i = 0; i < 16; i++) snapM[i] = shadowM[i];
      flagM = 1'b1;
    end
    bi = 7 - gB;
    ts = (bi >= 4) ? gF : gF + 16;
    expBit = p;
    if (enM && gS == 16) begin
      if (gF == 0)        expBit = (bi >= 4) ? 1'b0 : snapM[0][bi];
      else if (hwM[ts])   expBit = s;
      else if (swM[ts])   expBit = snapM[gF][bi];
    end
    if (doWr) begin
      if (a < 16)                        shadowM[a[3:0]] = d[7:0];
      else if (a == 16)                  enM = d[0];
      else if (a == 17)                  swM = d;
      else if (a == 18)                  hwM = d;
      else if (a == 19 && d[0] && !bnd)  flagM = 1'b0;
    end
    @(posedge clk); #1;
    if (pcmOut !== expBit) frameErr++;
    if (mfFlag !== flagM)  flagErr++;
    gB++;
    if (gB == 8) begin
      gB = 0; gS++;
      if (gS == 32) begin
        gS = 0;
        check(frameErr == 0, curTag, $sformatf("frame %0d bit mismatches", gF), frameErr, 0);
        check(flagErr == 0, "R8", $sformatf("flag mismatches in frame %0d", gF), flagErr, 0);
        frameErr = 0; flagErr = 0;
        gF = (gF + 1) % 16;
      end
    end
  endtask

  task automatic idle();
    step(1'b0, '0, '0);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    step(1'b1, a, d);
  endtask

  task automatic runTo(input int f, input int s, input int b);
    while (!(gF == f && gS == s && gB == b)) idle();
  endtask

  // read one output byte of the slot at the current position
  task automatic grabByte(output logic [7:0] outB, output logic [7:0] inB);
    outB = '0; inB = '0;
    for (int k = 0; k < 8; k++) begin
      idle();
      outB = {outB[6:0], pcmOut};
      inB  = {inB[6:0], pcmIn};
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [7:0] ob, ib, oldV, newV;
    for (int i = 0; i < 16; i++) begin shadowM[i] = '0; snapM[i] = '0; end

    repeat (3) @(posedge clk);
    #1;
    check(pcmOut === 1'b0, "R10", "pcmOut during reset", pcmOut, 0);
    check(mfFlag === 1'b0, "R10", "mfFlag during reset", mfFlag, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(mfFlag === 1'b0, "R10", "mfFlag after reset", mfFlag, 0);
    check(pcmOut === 1'b0, "R10", "pcmOut after reset", pcmOut, 0);

    // reset masks are zero: a whole multiframe passes through, enable is 0
    curTag = "R10";
    idle();
    runTo(0, 0, 0);

    for (int r = 0; r < NROWS; r++) begin
      curTag = ROW_TAG[r];
      wr(ADDR_SWEN, ROWS[r].sw);
      wr(ADDR_HWSEL, ROWS[r].hw);
      wr(ADDR_CTL, {31'b0, ROWS[r].en});
      for (int i = 0; i < 16; i++)
        wr(ADDR_W'(i), {24'b0, 8'(ROWS[r].seed + 8'(i * 59))});
      runTo(0, 0, 0);
      idle();
      runTo(0, 0, 0);
    end

    // directed: enable, software on every slot
    curTag = "R7";
    wr(ADDR_HWSEL, 32'h0);
    wr(ADDR_SWEN, 32'hFFFF_FFFF);
    wr(ADDR_CTL, 32'h1);
    runTo(0, 0, 0);
    idle();
    check(mfFlag === 1'b1, "R8", "flag after multiframe start", mfFlag, 1);

    runTo(0, 16, 0);
    grabByte(ob, ib);
    check(ob === {4'h0, snapM[0][3:0]}, "R3", "frame 0 slot 16 byte", ob, {4'h0, snapM[0][3:0]});
    runTo(1, 5, 0);
    grabByte(ob, ib);
    check(ob === ib, "R1", "slot 5 passes through", ob, ib);

    // write mid-multiframe
    oldV = snapM[9];
    newV = ~oldV;
    runTo(4, 3, 0);
    wr(ADDR_W'(9), {24'b0, newV});
    runTo(9, 16, 0);
    grabByte(ob, ib);
    check(ob === oldV, "R7", "mid-multiframe write not yet used", ob, oldV);
    runTo(9, 16, 0);
    grabByte(ob, ib);
    check(ob === newV, "R7", "write used in next multiframe", ob, newV);

    // write on the boundary bit itself
    oldV = shadowM[2];
    newV = oldV ^ 8'h5A;
    runTo(0, 0, 0);
    wr(ADDR_W'(2), {24'b0, newV});
    runTo(2, 16, 0);
    grabByte(ob, ib);
    check(ob === oldV, "R7", "boundary-cycle write waits a multiframe", ob, oldV);

    // flag clear
    runTo(5, 0, 0);
    wr(ADDR_STAT, 32'h1);
    check(mfFlag === 1'b0, "R9", "flag cleared by write of 1", mfFlag, 0);
    runTo(0, 0, 0);
    wr(ADDR_STAT, 32'h1);
    check(mfFlag === 1'b1, "R9", "set wins over same-cycle clear", mfFlag, 1);
    runTo(2, 16, 0);
    grabByte(ob, ib);
    check(ob === newV, "R7", "boundary-cycle write in next multiframe", ob, newV);
    runTo(3, 0, 0);
    wr(ADDR_STAT, 32'h0);
    check(mfFlag === 1'b1, "R9", "write of 0 leaves flag", mfFlag, 1);
    wr(ADDR_STAT, 32'h1);
    check(mfFlag === 1'b0, "R9", "flag cleared again", mfFlag, 0);

    // hardware wins over software on slot 7 upper nibble
    curTag = "R6";
    wr(ADDR_HWSEL, 32'h0000_0080);
    runTo(0, 0, 0);
    idle();
    runTo(7, 16, 0);
    begin
      logic [7:0] sb;
      sb = '0;
      ob = '0;
      for (int k = 0; k < 8; k++) begin
        idle();
        ob = {ob[6:0], pcmOut};
        sb = {sb[6:0], sigIn};
      end
      check(ob[7:4] === sb[7:4], "R6", "hardware nibble over software", ob[7:4], sb[7:4]);
      check(ob[3:0] === snapM[7][3:0], "R4", "software lower nibble", ob[3:0], snapM[7][3:0]);
    end
    runTo(0, 0, 0);

    done = 1'b1;
    finishRun();
  end
endmodule